// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device side of a serial flash's four-wire serial port. It oversamples the serial clock, select and data-in pins with the chip's own clock. Each instruction is built from the bits taken on rising serial-clock edges while select is low. The block then gathers the address and filler bytes that the instruction calls for. It streams read data, the status byte or a fixed signature back on falling serial-clock edges, most significant bit first. A clock that idles low and a clock that idles high are both accepted, because only edges are used.

The memory array sits behind a plain read port. The block presents an address with a read strobe and takes the byte back combinationally in the same cycle. Writes and erases are not performed here. Each one is forwarded as a single-cycle request to a separate status and protection block, which decides whether to act on it. That block also supplies the busy flag and the status byte.

Top module: `spi_flash_front`

## Requirements
- R1: After reset, and at all times while select is high, `miso_oe` is low, meaning the data-out pin is high impedance. `miso_oe` is also low during instruction, address and filler bytes. It goes high only while a data byte is being shifted out.
- R2: Input bits are taken on the rising serial-clock edge, most significant bit first. Output bits change after the falling edge. Both clock idle levels work.
- R3: Opcode 03h takes a 3-byte address, most significant byte first. Only the low 18 bits are kept. The block then returns `mem_rdata` for that address, with `mem_rd` pulsing once per byte.
- R4: During a read the address advances by one after each byte and wraps from 3FFFFh to 0. Streaming continues until select goes high.
- R5: Opcode 0Bh behaves like 03h, except that one filler byte follows the address before data starts.
- R6: Opcode 05h streams `status_in`, loaded afresh at the start of each byte.
- R7: Opcode ABh is followed by three filler bytes and then returns 11h in every byte. Deselecting after this opcode leaves deep power-down.
- R8: Opcode B9h enters deep power-down when select goes high. From then on every opcode except ABh is ignored: no output and no request.
- R9: An 03h or 0Bh opcode received while `busy` is high is rejected. No data is driven and `mem_rd` does not pulse.
- R10: Opcodes 06h, 04h and C7h issue a request when select goes high at a byte boundary. The request kinds are 0 (06h), 1 (04h) and 6 (C7h), with `rq_addr` and `rq_data` both 0.
- R11: Opcode 01h followed by one data byte issues kind 2 with that byte in `rq_data` when select goes high.
- R12: Opcode 02h takes an address and then data bytes. Each data byte issues kind 3 with its address and data. The low 8 address bits wrap within the 256-byte page. Deselecting at a byte boundary then issues kind 4 with the start address.
- R13: Opcode D8h with an address issues kind 5 with that address when select goes high.
- R14: If select goes high mid-byte, or a full byte past the instruction's end arrives, nothing is committed. An unknown opcode is ignored. Every new select starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock pin |
| csn | input | 1 | Active-low select pin |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the data-out pad; the pad is high impedance when low |
| busy | input | 1 | Program or erase cycle in progress |
| status_in | input | 8 | Status byte from the status block |
| mem_raddr | output | 18 | Array read address |
| mem_rd | output | 1 | Array read strobe, one per byte fetched |
| mem_rdata | input | 8 | Array read data, valid in the same cycle as the address |
| rq_valid | output | 1 | Request strobe to the status block |
| rq_kind | output | 3 | Request kind (codes in R10 to R13) |
| rq_addr | output | 18 | Request address |
| rq_data | output | 8 | Request data |

## Verification
The hardest conditions to reach from the ports depend on history across separate select periods. Deep power-down has to be entered in one transaction and then tried against writes and reads in later ones. Read rejection needs `busy` raised before the opcode arrives. The stimulus strings whole transactions together: an idle-high clock read that starts two bytes below the top of memory to force the wrap, partial-byte deselects to leave aborted state behind, and an ABh sequence that must both return the signature and bring reads back. Requests are compared against a queue of expected items that the driver fills before each transaction ends.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ,
    OP_FREAD, OP_PP, OP_SE, OP_BE, OP_DP, OP_RES
  } op_e;

  typedef enum logic [2:0] {
    RQ_WREN = 3'd0, RQ_WRDI = 3'd1, RQ_WRSR = 3'd2, RQ_PBYTE = 3'd3,
    RQ_PGO = 3'd4, RQ_SE = 3'd5, RQ_BE = 3'd6
  } rq_e;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_DONE, PH_SKIP} phase_e;

  typedef enum logic [1:0] {SRC_MEM, SRC_STAT, SRC_SIG} src_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] n_addr;
    logic [1:0] n_dummy;
    logic       dout;
    logic       din;
    src_e       src;
  } op_info_t;

  // Per-opcode byte counts and data direction.
  function automatic op_info_t decode_op(input logic [7:0] code);
    op_info_t r;
    r.op = OP_NONE; r.n_addr = 2'd0; r.n_dummy = 2'd0;
    r.dout = 1'b0; r.din = 1'b0; r.src = SRC_MEM;
    case (code)
      8'h06: r.op = OP_WREN;
      8'h04: r.op = OP_WRDI;
      8'h05: begin r.op = OP_RDSR; r.dout = 1'b1; r.src = SRC_STAT; end
      8'h01: begin r.op = OP_WRSR; r.din = 1'b1; end
      8'h03: begin r.op = OP_READ; r.n_addr = 2'd3; r.dout = 1'b1; end
      8'h0B: begin r.op = OP_FREAD; r.n_addr = 2'd3; r.n_dummy = 2'd1; r.dout = 1'b1; end
      8'h02: begin r.op = OP_PP; r.n_addr = 2'd3; r.din = 1'b1; end
      8'hD8: begin r.op = OP_SE; r.n_addr = 2'd3; end
      8'hC7: r.op = OP_BE;
      8'hB9: r.op = OP_DP;
      8'hAB: begin r.op = OP_RES; r.n_dummy = 2'd3; r.dout = 1'b1; r.src = SRC_SIG; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic phase_e phase_after_addr(input op_info_t i);
    if (i.n_dummy != 2'd0) return PH_DUMMY;
    if (i.dout || i.din) return PH_DATA;
    return PH_DONE;
  endfunction

  function automatic phase_e phase_after_cmd(input op_info_t i);
    if (i.n_addr != 2'd0) return PH_ADDR;
    return phase_after_addr(i);
  endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_start,
  output logic sel_end,
  output logic mosi_s
);
  localparam int LAST = STAGES - 1;

  // Bit order in each stage: {mosi, csn, sck}. All three share one pipe so
  // their relative timing is kept.
  logic [2:0] pipe [STAGES];
  logic       sck_d, csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b010;
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      pipe[0] <= {mosi, csn, sck};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_d <= pipe[LAST][0];
      csn_d <= pipe[LAST][1];
    end
  end

  assign sck_rise  = pipe[LAST][0] & ~sck_d;
  assign sck_fall  = ~pipe[LAST][0] & sck_d;
  assign sel       = ~pipe[LAST][1];
  assign sel_start = csn_d & ~pipe[LAST][1];
  assign sel_end   = ~csn_d & pipe[LAST][1];
  assign mosi_s    = pipe[LAST][2];
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
  import sfe_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sel,
  input  logic              sel_start,
  input  logic              sel_end,
  input  logic              mosi_s,
  input  logic              busy,
  output logic              out_phase,
  output src_e              out_src,
  output logic              load,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rq_valid,
  output rq_e               rq_kind,
  output logic [ADDR_W-1:0] rq_addr,
  output logic [7:0]        rq_data
);
  localparam int KEEP = ADDR_W - 8;

  function automatic logic [ADDR_W-1:0] next_linear(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] next_in_page(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] low;
    low = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], low};
  endfunction

  phase_e            phase;
  op_info_t          info;
  logic [2:0]        bit_cnt;
  logic [1:0]        byte_cnt;
  logic [6:0]        sh_in;
  logic [ADDR_W-1:0] addr_q, start_q;
  logic [7:0]        data_q;
  logic              got_q, dp_q, load_q;

  logic [7:0] in_byte;
  op_info_t   dec;
  logic       accept;
  logic       rd_op;

  assign in_byte = {sh_in, mosi_s};
  assign dec     = decode_op(in_byte);
  assign rd_op   = (dec.op == OP_READ) || (dec.op == OP_FREAD);
  assign accept  = (dec.op != OP_NONE) && (!dp_q || dec.op == OP_RES) && !(busy && rd_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_SKIP;
      info     <= '{op: OP_NONE, n_addr: 2'd0, n_dummy: 2'd0, dout: 1'b0, din: 1'b0, src: SRC_MEM};
      bit_cnt  <= 3'd0;
      byte_cnt <= 2'd0;
      sh_in    <= 7'd0;
      addr_q   <= '0;
      start_q  <= '0;
      data_q   <= 8'd0;
      got_q    <= 1'b0;
      dp_q     <= 1'b0;
      load_q   <= 1'b0;
      rq_valid <= 1'b0;
      rq_kind  <= RQ_WREN;
      rq_addr  <= '0;
      rq_data  <= 8'd0;
    end else begin
      load_q   <= 1'b0;
      rq_valid <= 1'b0;
      if (load_q && info.src == SRC_MEM) addr_q <= next_linear(addr_q);
      if (sel_start) begin
        phase    <= PH_CMD;
        bit_cnt  <= 3'd0;
        byte_cnt <= 2'd0;
        got_q    <= 1'b0;
      end else if (sel && sck_rise) begin
        sh_in   <= in_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_CMD: begin
              info <= dec;
              if (!accept) phase <= PH_SKIP;
              else begin
                phase  <= phase_after_cmd(dec);
                load_q <= (phase_after_cmd(dec) == PH_DATA) && dec.dout;
              end
            end
            PH_ADDR: begin
              addr_q   <= {addr_q[KEEP-1:0], in_byte};
              byte_cnt <= byte_cnt + 2'd1;
              if (byte_cnt == 2'd2) begin
                start_q  <= {addr_q[KEEP-1:0], in_byte};
                byte_cnt <= 2'd0;
                phase    <= phase_after_addr(info);
                load_q   <= (phase_after_addr(info) == PH_DATA) && info.dout;
              end
            end
            PH_DUMMY: begin
              byte_cnt <= byte_cnt + 2'd1;
              if (byte_cnt == info.n_dummy - 2'd1) begin
                byte_cnt <= 2'd0;
                phase    <= PH_DATA;
                load_q   <= info.dout;
              end
            end
            PH_DATA: begin
              if (info.dout) load_q <= 1'b1;
              if (info.op == OP_PP) begin
                rq_valid <= 1'b1;
                rq_kind  <= RQ_PBYTE;
                rq_addr  <= addr_q;
                rq_data  <= in_byte;
                addr_q   <= next_in_page(addr_q);
                got_q    <= 1'b1;
              end
              if (info.op == OP_WRSR) begin
                data_q <= in_byte;
                got_q  <= 1'b1;
                phase  <= PH_DONE;
              end
            end
            PH_DONE: phase <= PH_SKIP;
            default: ;
          endcase
        end
      end else if (sel_end && bit_cnt == 3'd0) begin
        rq_addr <= '0;
        rq_data <= 8'd0;
        case (phase)
          PH_DONE: begin
            case (info.op)
              OP_WREN: begin rq_valid <= 1'b1; rq_kind <= RQ_WREN; end
              OP_WRDI: begin rq_valid <= 1'b1; rq_kind <= RQ_WRDI; end
              OP_BE:   begin rq_valid <= 1'b1; rq_kind <= RQ_BE; end
              OP_SE:   begin rq_valid <= 1'b1; rq_kind <= RQ_SE; rq_addr <= addr_q; end
              OP_WRSR: begin rq_valid <= got_q; rq_kind <= RQ_WRSR; rq_data <= data_q; end
              OP_DP:   dp_q <= 1'b1;
              default: ;
            endcase
          end
          PH_DATA: begin
            if (info.op == OP_PP && got_q) begin
              rq_valid <= 1'b1;
              rq_kind  <= RQ_PGO;
              rq_addr  <= start_q;
            end
            if (info.op == OP_RES) dp_q <= 1'b0;
          end
          PH_DUMMY: if (info.op == OP_RES) dp_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign out_phase = (phase == PH_DATA) && info.dout;
  assign out_src   = info.src;
  assign load      = load_q;
  assign mem_rd    = load_q && (info.src == SRC_MEM);
  assign mem_addr  = addr_q;

  AST_RD_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (phase == PH_DATA)); // R3
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_addr == '1) |=> (mem_addr == '0)); // R4
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> $past(sel_end || sck_rise)); // R10
  AST_DP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> !$past(dp_q)); // R8
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx
  import sfe_pkg::*;
#(
  parameter logic [7:0] SIG = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       sck_fall,
  input  logic       out_phase,
  input  logic       load,
  input  src_e       src,
  input  logic [7:0] mem_rdata,
  input  logic [7:0] status_in,
  output logic       miso,
  output logic       miso_oe
);
  logic [7:0] sh, load_byte;

  always_comb begin
    case (src)
      SRC_MEM:  load_byte = mem_rdata;
      SRC_STAT: load_byte = status_in;
      default:  load_byte = SIG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= 8'd0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (!sel) begin
      miso_oe <= 1'b0;
    end else if (load) begin
      sh <= load_byte;
    end else if (sck_fall && out_phase) begin
      miso    <= sh[7];
      sh      <= {sh[6:0], 1'b0};
      miso_oe <= 1'b1;
    end
  end

  AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso_oe); // R1
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import sfe_pkg::*;
#(
  parameter int         ADDR_W      = 18,
  parameter int         PAGE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SIGNATURE   = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              busy,
  input  logic [7:0]        status_in,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              rq_valid,
  output logic [2:0]        rq_kind,
  output logic [ADDR_W-1:0] rq_addr,
  output logic [7:0]        rq_data
);
  logic   sck_rise, sck_fall, sel, sel_start, sel_end, mosi_s;
  logic   out_phase, load;
  src_e   out_src;
  rq_e    kind_e;

  sfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel),
    .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s)
  );

  sfe_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sel(sel),
    .sel_start(sel_start), .sel_end(sel_end), .mosi_s(mosi_s), .busy(busy),
    .out_phase(out_phase), .out_src(out_src), .load(load), .mem_rd(mem_rd),
    .mem_addr(mem_raddr), .rq_valid(rq_valid), .rq_kind(kind_e),
    .rq_addr(rq_addr), .rq_data(rq_data)
  );

  sfe_tx #(.SIG(SIGNATURE)) u_tx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_fall(sck_fall),
    .out_phase(out_phase), .load(load), .src(out_src),
    .mem_rdata(mem_rdata), .status_in(status_in),
    .miso(miso), .miso_oe(miso_oe)
  );

  assign rq_kind = kind_e;

  AST_OE_OUT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> out_phase); // R1
endmodule

// File: tb/sim_spi_flash_front.sv
module sim_spi_flash_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int AW = 18;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic miso, miso_oe, mem_rd, rq_valid;
  logic [AW-1:0] mem_raddr, rq_addr;
  logic [7:0] mem_rdata, rq_data;
  logic [2:0] rq_kind;

  spi_flash_front u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .busy(busy), .status_in(status_in),
    .mem_raddr(mem_raddr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .rq_valid(rq_valid), .rq_kind(rq_kind), .rq_addr(rq_addr), .rq_data(rq_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model(input logic [AW-1:0] a);
    return a[7:0] ^ {a[15:10], a[17:16]} ^ 8'h5A;
  endfunction
  assign mem_rdata = model(mem_raddr);

  typedef struct {
    logic [2:0]    kind;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    string         req;
  } exp_t;
  exp_t expq[$];

  int checks = 0, fails = 0, rd_cnt = 0;
  logic cpol = 1'b0;
  bit done = 1'b0;

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] k, input logic [AW-1:0] a, input logic [7:0] d, input string req);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.req = req;
    expq.push_back(e);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && mem_rd) rd_cnt++;
    if (rst_n && rq_valid) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected request actual=%0h expected=none", {rq_kind, rq_addr, rq_data});
      end else begin
        e = expq.pop_front();
        check_eq(e.req, {3'd0, rq_kind, rq_addr, rq_data}, {3'd0, e.kind, e.addr, e.data});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on(input logic pol);
    cpol = pol; sck = pol; tick(4);
    csn = 1'b0; tick(HALF);
  endtask

  task automatic sel_off();
    tick(HALF); csn = 1'b1; tick(12);
  endtask

  task automatic xfer(input logic [7:0] tx, input int n, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    rx = 8'd0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      if (cpol) sck = 1'b0;
      mosi = tx[i];
      tick(HALF);
      rx = {rx[6:0], miso};
      oe_all &= miso_oe;
      oe_any |= miso_oe;
      sck = 1'b1;
      tick(HALF);
      if (!cpol) sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] rx; logic a, b;
    xfer(tx, 8, rx, a, b);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic expect_byte(input logic [7:0] exp, input string req);
    logic [7:0] rx; logic a, b;
    xfer(8'h00, 8, rx, a, b);
    check_eq(req, {23'd0, a, rx}, {23'd0, 1'b1, exp});
  endtask

  task automatic expect_quiet(input string req);
    logic [7:0] rx; logic a, b;
    xfer(8'h00, 8, rx, a, b);
    check_eq(req, {31'd0, b}, 32'd0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    report();
  end

  initial begin
    logic [7:0] rx; logic a, b;
    int rd0;
    tick(3); rst_n = 1'b1; tick(4);
    // R1: reset state
    check_eq("R1 reset oe", {31'd0, miso_oe}, 32'd0);
    check_eq("R1 reset rq", {31'd0, rq_valid}, 32'd0);

    // R3 R2: read, idle-low clock, upper address bits ignored
    sel_on(1'b0); send(8'h03); send_addr(24'hFC0123);
    for (int i = 0; i < 4; i++) expect_byte(model(18'h00123 + i), "R3 read mode0");
    sel_off();
    check_eq("R1 deselected oe", {31'd0, miso_oe}, 32'd0);

    // R4 R2: wrap at top, idle-high clock
    sel_on(1'b1); send(8'h03); send_addr(24'h03FFFE);
    expect_byte(model(18'h3FFFE), "R4 wrap");
    expect_byte(model(18'h3FFFF), "R4 wrap");
    expect_byte(model(18'h00000), "R4 wrap");
    expect_byte(model(18'h00001), "R4 wrap");
    sel_off();

    // R5: fast read with one filler byte
    sel_on(1'b0); send(8'h0B); send_addr(24'h012340);
    expect_quiet("R5 filler hi-z");
    for (int i = 0; i < 3; i++) expect_byte(model(18'h12340 + i), "R5 fast read");
    sel_off();

    // R6: status stream reloads each byte
    status_in = 8'hA5;
    sel_on(1'b1); send(8'h05);
    status_in = 8'h3C;
    expect_byte(8'hA5, "R6 status");
    expect_byte(8'h3C, "R6 status");
    sel_off();

    // R10: single-byte commands
    push(3'd0, '0, 8'h00, "R10 wren"); sel_on(1'b0); send(8'h06); sel_off();
    push(3'd1, '0, 8'h00, "R10 wrdi"); sel_on(1'b1); send(8'h04); sel_off();
    push(3'd6, '0, 8'h00, "R10 bulk"); sel_on(1'b0); send(8'hC7); sel_off();

    // R11: write status
    push(3'd2, '0, 8'h3C, "R11 wrsr"); sel_on(1'b0); send(8'h01); send(8'h3C); sel_off();

    // R12: page program with in-page wrap
    push(3'd3, 18'h102FE, 8'h11, "R12 pbyte");
    push(3'd3, 18'h102FF, 8'h22, "R12 pbyte");
    push(3'd3, 18'h10200, 8'h33, "R12 pbyte wrap");
    push(3'd4, 18'h102FE, 8'h00, "R12 commit");
    sel_on(1'b1); send(8'h02); send_addr(24'hC102FE);
    send(8'h11); send(8'h22); send(8'h33); sel_off();

    // R13: sector erase
    push(3'd5, 18'h20000, 8'h00, "R13 sector");
    sel_on(1'b0); send(8'hD8); send_addr(24'h020000); sel_off();

    // R14: aborts and unknown opcode leave nothing behind
    sel_on(1'b0); xfer(8'h06, 5, rx, a, b); sel_off();
    sel_on(1'b0); send(8'hD8); send(8'h02); xfer(8'h00, 4, rx, a, b); sel_off();
    sel_on(1'b0); send(8'h06); send(8'h00); sel_off();
    sel_on(1'b0); send(8'hFF); expect_quiet("R14 unknown opcode"); sel_off();
    push(3'd0, '0, 8'h00, "R14 fresh start"); sel_on(1'b0); send(8'h06); sel_off();
    check_eq("R14 queue drained", expq.size(), 32'd0);

    // R9: read rejected while busy
    busy = 1'b1; rd0 = rd_cnt;
    sel_on(1'b0); send(8'h03); send_addr(24'h000010);
    expect_quiet("R9 busy read"); expect_quiet("R9 busy read"); sel_off();
    busy = 1'b0;
    check_eq("R9 no fetch", rd_cnt - rd0, 32'd0);

    // R8: deep power-down blocks everything but ABh
    sel_on(1'b0); send(8'hB9); sel_off();
    sel_on(1'b0); send(8'h06); sel_off();
    rd0 = rd_cnt;
    sel_on(1'b1); send(8'h03); send_addr(24'h000020); expect_quiet("R8 read in dp"); sel_off();
    sel_on(1'b0); send(8'h05); expect_quiet("R8 status in dp"); sel_off();
    check_eq("R8 no fetch", rd_cnt - rd0, 32'd0);

    // R7: signature and release
    sel_on(1'b0); send(8'hAB);
    for (int i = 0; i < 3; i++) expect_quiet("R7 filler hi-z");
    expect_byte(8'h11, "R7 signature"); expect_byte(8'h11, "R7 signature");
    sel_off();
    sel_on(1'b0); send(8'h03); send_addr(24'h000020);
    expect_byte(model(18'h00020), "R7 released read"); sel_off();

    tick(20);
    check_eq("R10 all requests seen", expq.size(), 32'd0);
    report();
  end
endmodule